// File: doc/BRIEF.md
# Serial Target Front End with Power-Up Lockout

This block sits between the pins of a serial memory-style target and its command decoder. It runs on a fast system clock and samples the serial clock, data-in and active-low chip select as ordinary synchronous inputs. On each chip-select falling edge it latches the clock mode from the level the serial clock holds at that instant. A high level selects mode 3 and a low level selects mode 0. In both modes it shifts in command bytes, most significant bit first, and shifts a response byte out. The serial output enable is held low unless the target is selected and past its lockout.

After power-good rises, two counters of timebase ticks gate the block. The shorter one keeps selection ignored until it expires, and the target then becomes able to take reads. The longer one gates program or erase requests coming from the decoder. A request that arrives too early is refused and raises a sticky flag, which only a power-good drop clears.

The controller has four states. LOCK is the reset and lockout state; it moves to ARM when the read lockout ends. ARM waits for chip select to be high and then moves to IDLE, the standby state. IDLE moves to SHIFT on a chip-select falling edge. SHIFT returns to IDLE when chip select goes high. A low level on power-good forces LOCK from any state.

Top module: `spi_tgt_frontend`

## Requirements
- R1: While power-good is low and just after it rises, `mode3` is 1 and `rd_ok`, `wr_ok` and `wr_rej` are 0.
- R2: `so_oe` is 0 during reset, whenever `cs_n` is high, and until the read lockout has ended. It is 1 only while selected in a transaction that began in standby.
- R3: A transaction starts only on a high-to-low `cs_n` edge seen in standby. If `cs_n` is already low when the read lockout ends, no byte is taken until `cs_n` has gone high and low again.
- R4: At each accepted `cs_n` falling edge, `mode3` takes the level of `sck`: 1 if high (mode 3), 0 if low (mode 0). It holds that value for the transaction.
- R5: Until RD_TICKS ticks have been counted after power-good rises, `rd_ok` is 0 and any selection is ignored: no byte is output and `so_oe` stays 0.
- R6: `wr_ok` rises after WR_TICKS ticks and stays high. `wr_grant` is 1 only when `wr_req` is 1 and `wr_ok` is 1.
- R7: `si` is sampled on rising `sck` edges, most significant bit first. After every 8th rising edge of a transaction, `cmd_byte` carries the byte and `cmd_valid` is high for one clock.
- R8: `so_d` shows bit 7 of `rsp_byte` from the chip-select falling edge. It shifts left on falling `sck` edges, except that the first falling edge of a mode-3 transaction is skipped. The falling edge after each complete byte reloads `rsp_byte`.
- R9: If `cs_n` rises before 8 bits have arrived, the partial byte is discarded and the next transaction starts a fresh byte.
- R10: `wr_req` while `wr_ok` is 0 sets `wr_rej`. The flag stays set until power-good goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power-good; low acts as asynchronous reset |
| tick | input | 1 | Timebase pulse counted by the lockout timers |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Chip select, active low |
| rsp_byte | input | 8 | Byte to shift out, taken at each byte start |
| wr_req | input | 1 | Program/erase request from the decoder |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high impedance) |
| cmd_byte | output | 8 | Last complete byte received |
| cmd_valid | output | 1 | One-clock pulse when `cmd_byte` is new |
| mode3 | output | 1 | Clock mode of the current or last transaction |
| rd_ok | output | 1 | Read lockout over |
| wr_ok | output | 1 | Write lockout over |
| wr_grant | output | 1 | Request accepted |
| wr_rej | output | 1 | Sticky: a request came before `wr_ok` |

## Verification
The checker assumes that `sck` and `cs_n` are synchronous to `clk` and that each level is held for at least two clocks. Under that assumption every serial edge is seen as one clean transition, and two byte completions can never fall in adjacent clocks. It also assumes `cs_n` does not change in the same clock as an `sck` edge. The bench drives all pins on the falling system-clock edge, holds each serial half period for three clocks, and moves chip select only while `sck` rests at the level of the chosen mode.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_ARM   = 2'd1,
        ST_IDLE  = 2'd2,
        ST_SHIFT = 2'd3
    } fe_state_t;
endpackage

// File: rtl/spi_tgt_lockout.sv
module spi_tgt_lockout #(
    parameter int RD_TICKS = 70,
    parameter int WR_TICKS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic rd_ok,
    output logic wr_ok
);
    localparam int CNT_W = $clog2(WR_TICKS + 1);
    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_TICKS);
    localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WR_TICKS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick && cnt != WR_LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rd_ok = (cnt >= RD_LIM);
    assign wr_ok = (cnt == WR_LIM);
endmodule

// File: rtl/spi_tgt_edges.sv
module spi_tgt_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck && !sck_q;
    assign sck_fall = !sck && sck_q;
    assign cs_fall  = cs_q && !cs_n;
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         start_sck,
    input  logic         active,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         si,
    input  logic [W-1:0] rsp_byte,
    output logic         so_bit,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  rx_sr;
    logic [W-1:0]  tx_sr;
    logic          skip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            skip     <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                bit_cnt <= '0;
                skip    <= start_sck;
                tx_sr   <= rsp_byte;
            end else if (active) begin
                if (sck_rise) begin
                    rx_sr <= {rx_sr[W-2:0], si};
                    if (bit_cnt == LAST) begin
                        bit_cnt  <= '0;
                        rx_byte  <= {rx_sr[W-2:0], si};
                        rx_valid <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (sck_fall) begin
                    if (skip) begin
                        skip <= 1'b0;
                    end else if (bit_cnt == '0) begin
                        tx_sr <= rsp_byte;
                    end else begin
                        tx_sr <= {tx_sr[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so_bit = tx_sr[W-1];
endmodule

// File: rtl/spi_tgt_frontend.sv
module spi_tgt_frontend
    import spi_tgt_pkg::*;
#(
    parameter int RD_TICKS = 70,
    parameter int WR_TICKS = 20000
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              tick,
    input  logic              sck,
    input  logic              si,
    input  logic              cs_n,
    input  logic [BYTE_W-1:0] rsp_byte,
    input  logic              wr_req,
    output logic              so_d,
    output logic              so_oe,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_valid,
    output logic              mode3,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              wr_grant,
    output logic              wr_rej
);
    fe_state_t state;
    fe_state_t state_nx;
    logic      sck_rise;
    logic      sck_fall;
    logic      cs_fall;
    logic      so_bit;
    logic      start;

    spi_tgt_lockout #(
        .RD_TICKS(RD_TICKS),
        .WR_TICKS(WR_TICKS)
    ) lock_i (
        .clk  (clk),
        .rst_n(pwr_good),
        .tick (tick),
        .rd_ok(rd_ok),
        .wr_ok(wr_ok)
    );

    spi_tgt_edges edge_i (
        .clk     (clk),
        .rst_n   (pwr_good),
        .sck     (sck),
        .cs_n    (cs_n),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .cs_fall (cs_fall)
    );

    assign start = (state == ST_IDLE) && cs_fall;

    spi_tgt_shift #(
        .W(BYTE_W)
    ) shift_i (
        .clk      (clk),
        .rst_n    (pwr_good),
        .start    (start),
        .start_sck(sck),
        .active   (state == ST_SHIFT),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si       (si),
        .rsp_byte (rsp_byte),
        .so_bit   (so_bit),
        .rx_byte  (cmd_byte),
        .rx_valid (cmd_valid)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCK:  if (rd_ok)   state_nx = ST_ARM;
            ST_ARM:   if (cs_n)    state_nx = ST_IDLE;
            ST_IDLE:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_n)    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state  <= ST_LOCK;
            mode3  <= 1'b1;
            wr_rej <= 1'b0;
        end else begin
            state <= state_nx;
            if (start) begin
                mode3 <= sck;
            end
            if (wr_req && !wr_ok) begin
                wr_rej <= 1'b1;
            end
        end
    end

    always_comb begin
        so_oe    = (state == ST_SHIFT) && !cs_n;
        so_d     = so_oe ? so_bit : 1'b0;
        wr_grant = wr_req && wr_ok;
    end
endmodule

// File: rtl/spi_tgt_frontend_chk.sv
module spi_tgt_frontend_chk (
    input logic clk,
    input logic pwr_good,
    input logic so_oe,
    input logic mode3,
    input logic rd_ok,
    input logic wr_ok,
    input logic wr_req,
    input logic wr_grant,
    input logic wr_rej,
    input logic cmd_valid
);
    // R2
    oe_locked_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !rd_ok |-> !so_oe);

    // R5
    rd_ok_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        rd_ok |=> rd_ok);

    // R6
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        wr_ok |-> rd_ok);

    // R6
    grant_gate_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        wr_grant |-> (wr_ok && wr_req));

    // R10
    rej_set_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (wr_req && !wr_ok) |=> wr_rej);

    // R10
    rej_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        wr_rej |=> wr_rej);

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        so_oe |=> (!so_oe || $stable(mode3)));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        cmd_valid |=> !cmd_valid);
endmodule

bind spi_tgt_frontend spi_tgt_frontend_chk chk_i (
    .clk      (clk),
    .pwr_good (pwr_good),
    .so_oe    (so_oe),
    .mode3    (mode3),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .wr_req   (wr_req),
    .wr_grant (wr_grant),
    .wr_rej   (wr_rej),
    .cmd_valid(cmd_valid)
);

// File: tb/spi_tgt_frontend_tb_top.sv
module spi_tgt_frontend_tb_top;
    localparam int RD_T = 40;
    localparam int WR_T = 120;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       tick = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] rsp_byte = 8'hA5;
    logic       wr_req = 1'b0;
    logic       so_d;
    logic       so_oe;
    logic [7:0] cmd_byte;
    logic       cmd_valid;
    logic       mode3;
    logic       rd_ok;
    logic       wr_ok;
    logic       wr_grant;
    logic       wr_rej;

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] exp_q[$];

    spi_tgt_frontend #(
        .RD_TICKS(RD_T),
        .WR_TICKS(WR_T)
    ) dut_i (
        .clk      (clk),
        .pwr_good (pwr_good),
        .tick     (tick),
        .sck      (sck),
        .si       (si),
        .cs_n     (cs_n),
        .rsp_byte (rsp_byte),
        .wr_req   (wr_req),
        .so_d     (so_d),
        .so_oe    (so_oe),
        .cmd_byte (cmd_byte),
        .cmd_valid(cmd_valid),
        .mode3    (mode3),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .wr_grant (wr_grant),
        .wr_rej   (wr_rej)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected bytes as the design reports them
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R5/R9 unexpected byte", cmd_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(cmd_byte == e, "R7 byte", cmd_byte, e);
                end
            end
        end
    end

    task automatic cs_start(input logic m3);
        sck  = m3;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(3);
    endtask

    task automatic cs_end(input logic m3);
        if (!m3) begin
            sck = 1'b0;
            wait_clk(3);
        end
        cs_n = 1'b1;
        wait_clk(3);
    endtask

    // driver: pushes the expected byte, clocks nbits out MSB first
    task automatic send_bits(input logic [7:0] d, input int nbits, input bit accept,
                             input bit chk_so, input logic [7:0] exp_so);
        logic [7:0] got;
        got = '0;
        if (accept) exp_q.push_back(d);
        for (int i = 7; i > 7 - nbits; i--) begin
            sck = 1'b0;
            si  = d[i];
            wait_clk(3);
            got[i] = so_d;
            sck = 1'b1;
            wait_clk(3);
        end
        if (chk_so) check(got == exp_so, "R8 serial out", got, exp_so);
    endtask

    initial begin
        wait_clk(3);
        // R1 reset state, R2 output off in reset
        check(mode3 == 1'b1, "R1 mode3 reset", mode3, 1);
        check(!rd_ok && !wr_ok, "R1 lockouts reset", {rd_ok, wr_ok}, 0);
        check(wr_rej == 1'b0, "R1 wr_rej reset", wr_rej, 0);
        check(so_oe == 1'b0, "R2 oe in reset", so_oe, 0);
        pwr_good = 1'b1;
        wait_clk(1);
        check(mode3 == 1'b1 && !rd_ok, "R1 after release", {mode3, rd_ok}, 2);

        // R5: selection during read lockout is ignored
        cs_start(1'b0);
        check(so_oe == 1'b0, "R5 oe during lockout", so_oe, 0);
        send_bits(8'h99, 8, 1'b0, 1'b0, 8'h00);
        cs_end(1'b0);
        check(rd_ok == 1'b0, "R5 rd_ok still low", rd_ok, 0);

        // R3: chip select already low when lockout ends
        cs_n = 1'b0;
        wait (rd_ok);
        wait_clk(2);
        check(so_oe == 1'b0, "R3 oe without fresh fall", so_oe, 0);
        send_bits(8'h42, 8, 1'b0, 1'b0, 8'h00);
        cs_end(1'b0);

        // R6/R10: early write refused
        wr_req = 1'b1;
        wait_clk(1);
        check(wr_grant == 1'b0, "R6 early grant", wr_grant, 0);
        wr_req = 1'b0;
        wait_clk(1);
        check(wr_rej == 1'b1, "R10 rej set", wr_rej, 1);

        // mode 0, two bytes, response reloaded between bytes
        rsp_byte = 8'hA5;
        cs_start(1'b0);
        check(mode3 == 1'b0, "R4 mode0 latched", mode3, 0);
        check(so_oe == 1'b1, "R2 oe when selected", so_oe, 1);
        rsp_byte = 8'h5A;
        send_bits(8'h3C, 8, 1'b1, 1'b1, 8'hA5);
        send_bits(8'h81, 8, 1'b1, 1'b1, 8'h5A);
        cs_end(1'b0);
        check(so_oe == 1'b0, "R2 oe after deselect", so_oe, 0);

        // mode 3, first falling edge skipped
        rsp_byte = 8'hC3;
        cs_start(1'b1);
        check(mode3 == 1'b1, "R4 mode3 latched", mode3, 1);
        send_bits(8'hE7, 8, 1'b1, 1'b1, 8'hC3);
        cs_end(1'b1);

        // R9: partial byte discarded
        rsp_byte = 8'h96;
        cs_start(1'b0);
        send_bits(8'hFF, 5, 1'b0, 1'b0, 8'h00);
        cs_end(1'b0);
        cs_start(1'b0);
        send_bits(8'h24, 8, 1'b1, 1'b1, 8'h96);
        cs_end(1'b0);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

        // R6/R10: late write granted, flag sticky
        wait (wr_ok);
        wait_clk(1);
        wr_req = 1'b1;
        wait_clk(1);
        check(wr_grant == 1'b1, "R6 late grant", wr_grant, 1);
        wr_req = 1'b0;
        wait_clk(1);
        check(wr_rej == 1'b1, "R10 rej sticky", wr_rej, 1);

        // power drop while selected
        cs_start(1'b0);
        pwr_good = 1'b0;
        wait_clk(1);
        check(so_oe == 1'b0, "R2 oe on power drop", so_oe, 0);
        check(mode3 == 1'b1 && !wr_rej && !rd_ok, "R1 re-reset", {mode3, wr_rej, rd_ok}, 4);
        pwr_good = 1'b1;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);
        check(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule